// File: doc/BRIEF.md
# Load/Store Effective Address and Alignment Unit

This block sits between the register-read stage and the data memory port of a processor pipeline and handles one single-register load or store at a time. It takes a base value, either a register offset or a short zero-extended immediate, and the indexing controls (pre/post, add/subtract, writeback, load/store). From these it forms the wrapped modified base and picks the access address. It then issues one aligned memory request of byte, halfword or word size.

For a load, the read data comes back right-justified. The unit formats it in one of three ways. Misaligned word and unsigned halfword reads are rotated rather than faulted. Signed transfers are sign-extended. Unsigned bytes are zero-extended. The unit then presents one result beat carrying the destination write and the base writeback. When both writes target the same register, the loaded value wins and the base write is dropped. The instruction decoder, the shifter that produces register offsets, and the register file all sit outside this block.

The transfer kind arrives as a 3-bit code. Bit 2 clear selects the word/byte class, and in that class bit 0 set means an unsigned byte. Bit 2 set selects the halfword/signed class, and in that class bits [1:0] select the transfer: 01 is an unsigned halfword, 10 a signed byte, 11 a signed halfword, and 00 is illegal.

Top module: `ldst_agu`

## Requirements
- R1: The modified base equals base + offset when `op_up` is 1 and base − offset when it is 0, both taken modulo 2^XLEN. It is reported on `rn_data` with every result.
- R2: With `op_pre` = 1 the memory access uses the modified base. With `op_pre` = 0 it uses the unmodified base.
- R3: `rn_we` is asserted on a result beat exactly when (`op_wb` AND `op_pre`) OR NOT `op_pre`, unless R4 suppresses it. `rn_idx` carries `op_rn`.
- R4: On a load whose `op_rd` equals `op_rn`, `rn_we` stays low and `rd_we` writes the loaded value. The loaded data is therefore the register's final value under every writeback mode.
- R5: A word load (kind 000) requests size 2 at the access address with bits [1:0] cleared. The result is the 32-bit read data rotated right by 8 × address[1:0].
- R6: An unsigned halfword load (kind 101) requests size 1 with address bit 0 cleared. The result is `mem_rdata[15:0]` zero-extended, then rotated right by 8 × address[0].
- R7: A signed halfword load (kind 111) requests size 1 with address bit 0 cleared. The result is `mem_rdata[15:0]` sign-extended from bit 15, with no rotation.
- R8: A byte load requests size 0 at the exact address. A signed byte (kind 110) sign-extends `mem_rdata[7:0]` from bit 7. An unsigned byte (kind 001) zero-extends it. Read-data bits above the transfer size are ignored.
- R9: Kind 100 is rejected. `rej` pulses for one cycle after acceptance, no memory request is made, and no register write occurs.
- R10: With `op_use_imm` = 1 the offset is `op_imm` zero-extended, and `op_offset` is ignored.
- R11: `mem_req_valid` and its fields hold stable until `mem_req_ready`. A load result beat (`res_valid`) appears one cycle after `mem_rvalid`. A store result beat appears one cycle after the request is taken.
- R12: A store drives `mem_we` = 1 and uses the same size and alignment as the matching load. The write data replicates the low byte (size 0) or low halfword (size 1) across all lanes; a word store drives the data unchanged. `rd_we` stays low.
- R13: After reset, `op_ready` = 1 and `mem_req_valid`, `res_valid`, `rej`, `rd_we` and `rn_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, operation accepted when valid |
| op_load | input | 1 | 1 = load, 0 = store |
| op_pre | input | 1 | Pre-index select |
| op_up | input | 1 | Add offset (1) or subtract (0) |
| op_wb | input | 1 | Writeback request |
| op_kind | input | 3 | Transfer kind code |
| op_use_imm | input | 1 | Use zero-extended immediate offset |
| op_imm | input | IMM_W | Immediate offset |
| op_base | input | XLEN | Base register value |
| op_offset | input | XLEN | Register offset value |
| op_sdata | input | XLEN | Store data |
| op_rd | input | REG_W | Destination/source register index |
| op_rn | input | REG_W | Base register index |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request taken |
| mem_addr | output | XLEN | Aligned request address |
| mem_size | output | 2 | 0 byte, 1 halfword, 2 word |
| mem_we | output | 1 | Write request |
| mem_wdata | output | XLEN | Lane-replicated write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | XLEN | Right-justified read data |
| res_valid | output | 1 | Result beat |
| rej | output | 1 | Illegal kind rejected |
| rd_we | output | 1 | Destination write enable |
| rd_idx | output | REG_W | Destination index |
| rd_data | output | XLEN | Formatted load value |
| rn_we | output | 1 | Base writeback enable |
| rn_idx | output | REG_W | Base index |
| rn_data | output | XLEN | Modified base |

## Verification
The properties assume that the memory raises `mem_rvalid` only while a load is waiting for its data, exactly once per load, and never while a request is still outstanding. They also assume that `op_valid` is only considered when `op_ready` is high. The bench keeps to these assumptions by playing the memory itself. It grants each request after a chosen stall, returns one data beat after a chosen latency, and offers a new operation only once the previous result beat has gone by. The bench's read data fills every bit of `mem_rdata` with noise, so any dependence on bits above the transfer size would show up.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } mem_sz_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2
   } agu_st_e;

   // kind code: bit2 = halfword/signed class, bits[1:0] sub-select
   function automatic logic kind_ok(input logic [2:0] k);
      return !(k[2] && (k[1:0] == 2'b00));
   endfunction

   function automatic mem_sz_e kind_size(input logic [2:0] k);
      if (!k[2])
         return k[0] ? SZ_BYTE : SZ_WORD;
      else
         return (k[1:0] == 2'b10) ? SZ_BYTE : SZ_HALF;
   endfunction

   function automatic logic kind_signed(input logic [2:0] k);
      return k[2] && k[1];
   endfunction

endpackage

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen #(
   parameter int XLEN  = 32,
   parameter int IMM_W = 12
) (
   input  logic [XLEN-1:0]  base,
   input  logic [XLEN-1:0]  offset,
   input  logic [IMM_W-1:0] imm,
   input  logic             use_imm,
   input  logic             pre,
   input  logic             up,
   input  logic             wb,
   output logic [XLEN-1:0]  mod_base,
   output logic [XLEN-1:0]  acc_addr,
   output logic             base_wr
);
   logic [XLEN-1:0] off_eff;

   // immediate is zero-extended to the datapath width
   assign off_eff  = use_imm ? XLEN'(imm) : offset;
   // wrapping add/subtract, carries beyond XLEN are dropped
   assign mod_base = up ? (base + off_eff) : (base - off_eff);
   assign acc_addr = pre ? mod_base : base;
   assign base_wr  = (wb && pre) || !pre;
endmodule

// File: rtl/ldst_store_fmt.sv
module ldst_store_fmt
   import ldst_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] addr,
   input  mem_sz_e         size,
   input  logic [XLEN-1:0] sdata,
   output logic [XLEN-1:0] req_addr,
   output logic [XLEN-1:0] wdata
);
   localparam int LANES = XLEN / 8;
   localparam int LB    = $clog2(LANES);

   always_comb begin
      req_addr = addr;
      case (size)
         SZ_WORD: req_addr[LB-1:0] = '0;
         SZ_HALF: req_addr[0]      = 1'b0;
         default: req_addr         = addr;
      endcase
   end

   // per-lane replication of the store data
   for (genvar j = 0; j < LANES; j++) begin : g_lane
      assign wdata[8*j +: 8] = (size == SZ_BYTE) ? sdata[7:0] :
                               (size == SZ_HALF) ? sdata[8*(j%2) +: 8] :
                                                   sdata[8*j +: 8];
   end
endmodule

// File: rtl/ldst_load_fmt.sv
module ldst_load_fmt
   import ldst_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0]                   rdata,
   input  logic [$clog2(XLEN/8)-1:0]         alow,
   input  mem_sz_e                           size,
   input  logic                              sgn,
   output logic [XLEN-1:0]                   result
);
   localparam int LANES = XLEN / 8;
   localparam int LB    = $clog2(LANES);

   logic [XLEN-1:0] word_rot;
   logic [XLEN-1:0] half_z;
   logic [XLEN-1:0] half_rot;
   logic [XLEN-1:0] half_s;
   logic [XLEN-1:0] byte_x;

   function automatic logic [7:0] pick_lane(input logic [XLEN-1:0] d,
                                            input logic [LB-1:0]   k,
                                            input int              j);
      logic [7:0] r;
      r = '0;
      for (int m = 0; m < LANES; m++) begin
         if (k == LB'(m)) r = d[8*((j + m) % LANES) +: 8];
      end
      return r;
   endfunction

   // rotate right by whole bytes: output lane j takes lane (j+k) mod LANES
   for (genvar j = 0; j < LANES; j++) begin : g_rot
      assign word_rot[8*j +: 8] = pick_lane(rdata, alow, j);
   end

   assign half_z   = {{(XLEN-16){1'b0}}, rdata[15:0]};
   assign half_rot = alow[0] ? {half_z[7:0], half_z[XLEN-1:8]} : half_z;
   assign half_s   = {{(XLEN-16){rdata[15]}}, rdata[15:0]};
   assign byte_x   = {{(XLEN-8){sgn & rdata[7]}}, rdata[7:0]};

   always_comb begin
      case (size)
         SZ_WORD: result = word_rot;
         SZ_HALF: result = sgn ? half_s : half_rot;
         default: result = byte_x;
      endcase
   end
endmodule

// File: rtl/ldst_agu.sv
module ldst_agu
   import ldst_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int IMM_W = 12,
   parameter int REG_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   output logic             op_ready,
   input  logic             op_load,
   input  logic             op_pre,
   input  logic             op_up,
   input  logic             op_wb,
   input  logic [2:0]       op_kind,
   input  logic             op_use_imm,
   input  logic [IMM_W-1:0] op_imm,
   input  logic [XLEN-1:0]  op_base,
   input  logic [XLEN-1:0]  op_offset,
   input  logic [XLEN-1:0]  op_sdata,
   input  logic [REG_W-1:0] op_rd,
   input  logic [REG_W-1:0] op_rn,
   output logic             mem_req_valid,
   input  logic             mem_req_ready,
   output logic [XLEN-1:0]  mem_addr,
   output logic [1:0]       mem_size,
   output logic             mem_we,
   output logic [XLEN-1:0]  mem_wdata,
   input  logic             mem_rvalid,
   input  logic [XLEN-1:0]  mem_rdata,
   output logic             res_valid,
   output logic             rej,
   output logic             rd_we,
   output logic [REG_W-1:0] rd_idx,
   output logic [XLEN-1:0]  rd_data,
   output logic             rn_we,
   output logic [REG_W-1:0] rn_idx,
   output logic [XLEN-1:0]  rn_data
);
   localparam int LANES = XLEN / 8;
   localparam int LB    = $clog2(LANES);

   // elaboration-time parameter checks
   if ((XLEN % 8) != 0 || XLEN < 32 || (LANES & (LANES - 1)) != 0) begin : g_bad_xlen
      $error("ldst_agu: XLEN must be a power-of-two byte count of at least 32 bits");
   end
   if (IMM_W < 1 || IMM_W > XLEN) begin : g_bad_imm
      $error("ldst_agu: IMM_W must lie in 1..XLEN");
   end
   if (REG_W < 1) begin : g_bad_reg
      $error("ldst_agu: REG_W must be at least 1");
   end

   agu_st_e          state;
   logic [XLEN-1:0]  c_mod, c_acc, c_req_addr, c_wdata;
   logic             c_base_wr;
   mem_sz_e          c_size;

   logic             q_load, q_sgn, q_wrbase;
   mem_sz_e          q_size;
   logic [LB-1:0]    q_alow;
   logic [XLEN-1:0]  q_mod, q_req_addr, q_wdata;
   logic [REG_W-1:0] q_rd, q_rn;
   logic [XLEN-1:0]  ld_res;

   assign c_size = kind_size(op_kind);

   ldst_addr_gen #(.XLEN(XLEN), .IMM_W(IMM_W)) u_addr (
      .base     (op_base),
      .offset   (op_offset),
      .imm      (op_imm),
      .use_imm  (op_use_imm),
      .pre      (op_pre),
      .up       (op_up),
      .wb       (op_wb),
      .mod_base (c_mod),
      .acc_addr (c_acc),
      .base_wr  (c_base_wr)
   );

   ldst_store_fmt #(.XLEN(XLEN)) u_st (
      .addr     (c_acc),
      .size     (c_size),
      .sdata    (op_sdata),
      .req_addr (c_req_addr),
      .wdata    (c_wdata)
   );

   ldst_load_fmt #(.XLEN(XLEN)) u_ld (
      .rdata  (mem_rdata),
      .alow   (q_alow),
      .size   (q_size),
      .sgn    (q_sgn),
      .result (ld_res)
   );

   assign op_ready      = (state == ST_IDLE);
   assign mem_req_valid = (state == ST_REQ);
   assign mem_addr      = q_req_addr;
   assign mem_size      = q_size;
   assign mem_we        = !q_load;
   assign mem_wdata     = q_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         res_valid  <= 1'b0;
         rej        <= 1'b0;
         rd_we      <= 1'b0;
         rn_we      <= 1'b0;
         rd_idx     <= '0;
         rn_idx     <= '0;
         rd_data    <= '0;
         rn_data    <= '0;
         q_load     <= 1'b0;
         q_sgn      <= 1'b0;
         q_wrbase   <= 1'b0;
         q_size     <= SZ_WORD;
         q_alow     <= '0;
         q_mod      <= '0;
         q_req_addr <= '0;
         q_wdata    <= '0;
         q_rd       <= '0;
         q_rn       <= '0;
      end else begin
         res_valid <= 1'b0;
         rej       <= 1'b0;
         rd_we     <= 1'b0;
         rn_we     <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (op_valid) begin
                  if (!kind_ok(op_kind)) begin
                     rej <= 1'b1;
                  end else begin
                     q_load     <= op_load;
                     q_sgn      <= kind_signed(op_kind);
                     q_wrbase   <= c_base_wr;
                     q_size     <= c_size;
                     q_alow     <= c_acc[LB-1:0];
                     q_mod      <= c_mod;
                     q_req_addr <= c_req_addr;
                     q_wdata    <= c_wdata;
                     q_rd       <= op_rd;
                     q_rn       <= op_rn;
                     state      <= ST_REQ;
                  end
               end
            end
            ST_REQ: begin
               if (mem_req_ready) begin
                  if (q_load) begin
                     state <= ST_WAIT;
                  end else begin
                     res_valid <= 1'b1;
                     rn_we     <= q_wrbase;
                     rn_data   <= q_mod;
                     rn_idx    <= q_rn;
                     rd_idx    <= q_rd;
                     state     <= ST_IDLE;
                  end
               end
            end
            ST_WAIT: begin
               if (mem_rvalid) begin
                  res_valid <= 1'b1;
                  rd_we     <= 1'b1;
                  rd_data   <= ld_res;
                  rd_idx    <= q_rd;
                  // loaded value owns a shared register: base write dropped
                  rn_we     <= q_wrbase && (q_rd != q_rn);
                  rn_data   <= q_mod;
                  rn_idx    <= q_rn;
                  state     <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ldst_agu_chk.sv
module ldst_agu_chk #(
   parameter int XLEN  = 32,
   parameter int REG_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             op_valid,
   input logic             op_ready,
   input logic [2:0]       op_kind,
   input logic             mem_req_valid,
   input logic             mem_req_ready,
   input logic [XLEN-1:0]  mem_addr,
   input logic [1:0]       mem_size,
   input logic             mem_we,
   input logic             mem_rvalid,
   input logic             res_valid,
   input logic             rej,
   input logic             rd_we,
   input logic [REG_W-1:0] rd_idx,
   input logic             rn_we,
   input logic [REG_W-1:0] rn_idx
);
   p_word_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_size == 2'd2) |-> (mem_addr[1:0] == 2'b00));

   p_half_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_size == 2'd1) |-> (mem_addr[0] == 1'b0));

   p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=>
         (mem_req_valid && $stable(mem_addr) && $stable(mem_size) && $stable(mem_we)));

   p_data_to_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rvalid && !op_ready && !mem_req_valid) |=> (res_valid && rd_we));

   p_single_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_we && rn_we) |-> (rd_idx != rn_idx));

   p_write_in_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_we || rn_we) |-> res_valid);

   p_bad_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_ready && op_kind == 3'b100) |=> (rej && !mem_req_valid && !res_valid));

   p_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !op_ready);
endmodule

bind ldst_agu ldst_agu_chk #(.XLEN(XLEN), .REG_W(REG_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .op_valid      (op_valid),
   .op_ready      (op_ready),
   .op_kind       (op_kind),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_addr      (mem_addr),
   .mem_size      (mem_size),
   .mem_we        (mem_we),
   .mem_rvalid    (mem_rvalid),
   .res_valid     (res_valid),
   .rej           (rej),
   .rd_we         (rd_we),
   .rd_idx        (rd_idx),
   .rn_we         (rn_we),
   .rn_idx        (rn_idx)
);

// File: tb/tb_ldst_agu.sv
`timescale 1ns/1ps
module tb_ldst_agu;
   localparam int XLEN  = 32;
   localparam int IMM_W = 12;
   localparam int REG_W = 4;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic             rst_n;
   logic             op_valid, op_ready, op_load, op_pre, op_up, op_wb, op_use_imm;
   logic [2:0]       op_kind;
   logic [IMM_W-1:0] op_imm;
   logic [XLEN-1:0]  op_base, op_offset, op_sdata;
   logic [REG_W-1:0] op_rd, op_rn;
   logic             mem_req_valid, mem_req_ready, mem_we, mem_rvalid;
   logic [XLEN-1:0]  mem_addr, mem_wdata, mem_rdata;
   logic [1:0]       mem_size;
   logic             res_valid, rej, rd_we, rn_we;
   logic [REG_W-1:0] rd_idx, rn_idx;
   logic [XLEN-1:0]  rd_data, rn_data;

   ldst_agu #(.XLEN(XLEN), .IMM_W(IMM_W), .REG_W(REG_W)) dut (.*);

   int total = 0;
   int bad   = 0;
   bit exp_res = 1'b0;
   bit done    = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] memw(input logic [31:0] a);
      return (a * 32'h9E37_79B1) ^ 32'hC3A5_5A3C;
   endfunction

   // per-clock comparison of the result strobe against the model (R11)
   always @(posedge clk) begin
      #1;
      if (rst_n && !done) chk("R11 res_valid per clock", {31'b0, res_valid}, {31'b0, exp_res});
   end

   task automatic run_op(input string tag, input bit ld, input bit pre, input bit up,
                         input bit wb, input logic [2:0] kind, input bit use_imm,
                         input logic [11:0] imm, input logic [31:0] base,
                         input logic [31:0] off, input logic [31:0] sd,
                         input logic [3:0] rd, input logic [3:0] rn,
                         input int stall, input int lat);
      logic [31:0] o, md, a, ra, wd, d, h, e;
      logic [1:0]  sz;
      bit          wbk, badk;
      o    = use_imm ? {20'b0, imm} : off;
      md   = up ? base + o : base - o;
      a    = pre ? md : base;
      wbk  = !pre || wb;
      badk = (kind == 3'b100);
      if (!kind[2]) sz = kind[0] ? 2'd0 : 2'd2;
      else          sz = (kind[1:0] == 2'b10) ? 2'd0 : 2'd1;
      ra = (sz == 2'd2) ? {a[31:2], 2'b00} : (sz == 2'd1) ? {a[31:1], 1'b0} : a;
      wd = (sz == 2'd0) ? {4{sd[7:0]}} : (sz == 2'd1) ? {2{sd[15:0]}} : sd;

      @(negedge clk);
      op_load = ld; op_pre = pre; op_up = up; op_wb = wb; op_kind = kind;
      op_use_imm = use_imm; op_imm = imm; op_base = base; op_offset = off;
      op_sdata = sd; op_rd = rd; op_rn = rn; op_valid = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
      if (badk) begin
         chk({tag, " R9 rej"}, {31'b0, rej}, 32'd1);
         chk({tag, " R9 no request"}, {31'b0, mem_req_valid}, 32'd0);
         chk({tag, " R9 no rd write"}, {31'b0, rd_we}, 32'd0);
         @(negedge clk);
         chk({tag, " R9 rej one cycle"}, {31'b0, rej}, 32'd0);
         chk({tag, " R9 still no request"}, {31'b0, mem_req_valid}, 32'd0);
         return;
      end
      chk({tag, " req valid"}, {31'b0, mem_req_valid}, 32'd1);
      chk({tag, " R2 addr"}, mem_addr, ra);
      chk({tag, " size"}, {30'b0, mem_size}, {30'b0, sz});
      chk({tag, " R12 we"}, {31'b0, mem_we}, {31'b0, !ld});
      if (!ld) chk({tag, " R12 wdata"}, mem_wdata, wd);
      for (int s = 0; s < stall; s++) begin
         @(negedge clk);
         chk({tag, " R11 held"}, mem_addr, ra);
      end
      mem_req_ready = 1'b1;
      if (!ld) exp_res = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      if (ld) begin
         chk({tag, " R11 no early result"}, {31'b0, res_valid}, 32'd0);
         for (int l = 0; l < lat; l++) @(negedge clk);
         d = memw(ra);
         mem_rdata  = d;
         mem_rvalid = 1'b1;
         exp_res    = 1'b1;
         @(negedge clk);
         mem_rvalid = 1'b0;
         mem_rdata  = 32'hDEAD_BEEF;
         case (kind)
            3'b000, 3'b010: e = 32'(({d, d}) >> (8 * a[1:0]));
            3'b101: begin
               h = {16'b0, d[15:0]};
               e = a[0] ? {h[7:0], h[31:8]} : h;
            end
            3'b111: e = {{16{d[15]}}, d[15:0]};
            3'b110: e = {{24{d[7]}}, d[7:0]};
            default: e = {24'b0, d[7:0]};
         endcase
         chk({tag, " rd_we"}, {31'b0, rd_we}, 32'd1);
         chk({tag, " rd_data"}, rd_data, e);
         chk({tag, " rd_idx"}, {28'b0, rd_idx}, {28'b0, rd});
      end else begin
         chk({tag, " R12 store rd_we"}, {31'b0, rd_we}, 32'd0);
      end
      chk({tag, " R3/R4 rn_we"}, {31'b0, rn_we}, {31'b0, wbk && !(ld && rd == rn)});
      chk({tag, " R1 rn_data"}, rn_data, md);
      chk({tag, " R3 rn_idx"}, {28'b0, rn_idx}, {28'b0, rn});
      exp_res = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; op_valid = 1'b0; op_load = 1'b0; op_pre = 1'b0; op_up = 1'b0;
      op_wb = 1'b0; op_kind = 3'b000; op_use_imm = 1'b0; op_imm = '0; op_base = '0;
      op_offset = '0; op_sdata = '0; op_rd = '0; op_rn = '0;
      mem_req_ready = 1'b0; mem_rvalid = 1'b0; mem_rdata = 32'hDEAD_BEEF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R13 op_ready", {31'b0, op_ready}, 32'd1);
      chk("R13 req", {31'b0, mem_req_valid}, 32'd0);
      chk("R13 res", {31'b0, res_valid}, 32'd0);
      chk("R13 rej", {31'b0, rej}, 32'd0);
      chk("R13 writes", {30'b0, rd_we, rn_we}, 32'd0);

      // R5 word loads at all four byte alignments
      for (int k = 0; k < 4; k++)
         run_op("R5 word align", 1, 1, 1, 0, 3'b000, 0, 0, 32'h0000_1000, 32'(k), 0, 1, 2, k % 2, k);
      // R6 unsigned halfword, both alignments
      run_op("R6 uhalf even", 1, 1, 1, 0, 3'b101, 0, 0, 32'h0000_2000, 0, 0, 3, 4, 0, 1);
      run_op("R6 uhalf odd",  1, 1, 1, 0, 3'b101, 0, 0, 32'h0000_2000, 1, 0, 3, 4, 2, 0);
      // R7 signed halfword, both alignments
      run_op("R7 shalf even", 1, 1, 1, 0, 3'b111, 0, 0, 32'h0000_2F00, 2, 0, 3, 4, 0, 0);
      run_op("R7 shalf odd",  1, 1, 1, 0, 3'b111, 0, 0, 32'h0000_2F00, 3, 0, 3, 4, 1, 2);
      // R8 bytes, signed and unsigned, several lanes
      for (int k = 0; k < 4; k++) begin
         run_op("R8 sbyte", 1, 1, 1, 0, 3'b110, 0, 0, 32'h0000_3000, 32'(k), 0, 6, 7, 0, 0);
         run_op("R8 ubyte", 1, 1, 1, 0, 3'b001, 0, 0, 32'h0000_3100, 32'(k), 0, 6, 7, 0, 1);
      end
      // R1 wrap both directions, R2 post-index uses old base
      run_op("R1 wrap up",   1, 1, 1, 1, 3'b000, 0, 0, 32'hFFFF_FFFC, 8, 0, 1, 2, 0, 0);
      run_op("R1R2 wrap dn", 1, 0, 0, 0, 3'b000, 0, 0, 32'h0000_0004, 8, 0, 1, 2, 1, 0);
      run_op("R2 post up",   1, 0, 1, 1, 3'b101, 0, 0, 32'h0000_5001, 32'h40, 0, 1, 2, 0, 0);
      // R10 immediate offset ignores op_offset
      run_op("R10 imm", 1, 1, 1, 1, 3'b000, 1, 12'hFFF, 32'h0001_0000, 32'hFFFF_0000, 0, 8, 9, 0, 0);
      run_op("R10 imm dn", 0, 1, 0, 1, 3'b000, 1, 12'h010, 32'h0001_0000, 32'h1234_5678, 32'hA1B2_C3D4, 8, 9, 0, 0);
      // R4 destination equals base under every writeback mode
      run_op("R4 pre wb",    1, 1, 1, 1, 3'b000, 0, 0, 32'h0000_6000, 5, 0, 5, 5, 0, 0);
      run_op("R4 pre nowb",  1, 1, 1, 0, 3'b000, 0, 0, 32'h0000_6000, 6, 0, 5, 5, 1, 1);
      run_op("R4 post",      1, 0, 1, 0, 3'b111, 0, 0, 32'h0000_6000, 7, 0, 5, 5, 0, 2);
      run_op("R4 post wbit", 1, 0, 0, 1, 3'b110, 0, 0, 32'h0000_6003, 7, 0, 5, 5, 2, 0);
      run_op("R4 store same",0, 1, 1, 1, 3'b000, 0, 0, 32'h0000_6000, 4, 32'h1122_3344, 5, 5, 0, 0);
      // R12 stores of each size, misaligned addresses
      run_op("R12 st word", 0, 1, 1, 0, 3'b000, 0, 0, 32'h0000_4000, 3, 32'hCAFE_F00D, 1, 2, 1, 0);
      run_op("R12 st half", 0, 1, 1, 1, 3'b101, 0, 0, 32'h0000_4000, 5, 32'h0000_BEEF, 1, 2, 0, 0);
      run_op("R12 st byte", 0, 0, 1, 0, 3'b001, 0, 0, 32'h0000_4007, 1, 32'h0000_005A, 1, 2, 3, 0);
      // R9 illegal kind, then a normal op still works
      run_op("R9 bad kind", 1, 1, 1, 1, 3'b100, 0, 0, 32'h0000_7000, 4, 0, 1, 2, 0, 0);
      run_op("R9 after", 1, 1, 1, 1, 3'b000, 0, 0, 32'h0000_7000, 4, 0, 1, 2, 0, 0);

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule